// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns single host requests into bus cycles on an 8-bit multiplexed NAND flash interface. Each request names one cycle kind: a command byte, an address byte, a data byte to write, or a data byte to read. Command, address and write data all leave on the same data lines. The device tells them apart only by the two latch-select lines, which the block drives for each kind. It holds chip select low for the whole strobe and pulses the write strobe so that the byte is captured on its rising edge. Reads use the separate read strobe, and the byte is sampled on the last clock before that strobe rises.

A command request can carry a wait flag. It is meant for the confirm command of a program or erase. With the flag set, the block ignores ready/busy for a short blanking window once the strobe is done. It then waits for ready/busy to come back high. A timeout counter ends the wait, so a device that never becomes ready cannot hang the host. The default timeout is 300,000 clocks, which is 3 ms at 100 MHz. That covers an erase time of about 2 ms and a program time of about 300 µs.

The host holds `req_valid` and the request fields steady until `ack` pulses, and it removes `req_valid` on the edge where it sees `ack`. Only one cycle is in flight at a time. The state machine has six states:

- IDLE goes to STROBE_LO when a request arrives.
- STROBE_LO goes to STROBE_HI after `WE_LOW` clocks.
- STROBE_HI goes to BLANK after `WE_HIGH` clocks for a command with the wait flag set, and to DONE for every other request.
- BLANK goes to BUSY after `BLANK_CYC` clocks.
- BUSY goes to DONE when the synchronised ready/busy is high, or when the timeout expires.
- DONE goes to IDLE after one clock.

Top module: `nand_bus_seq`

## Requirements
- R1: During and directly after reset, the flash lines are idle: `nand_ce_n`=1, `nand_cle`=0, `nand_ale`=0, `nand_we_n`=1, `nand_re_n`=1 and `nand_dq_oe`=0. The host outputs `ack`, `rd_valid` and `timeout_err` are 0. This also holds when reset is asserted in the middle of a cycle.
- R2: A command request (`req_kind`=2'b00) drives `nand_cle`=1, `nand_ale`=0 and `nand_ce_n`=0. It drives `nand_dq_oe`=1 with `req_byte` on `nand_dq_out` while `nand_we_n` is low.
- R3: An address request (`req_kind`=2'b01) drives `nand_ale`=1, `nand_cle`=0 and `nand_ce_n`=0. It drives `req_byte` on `nand_dq_out` with `nand_dq_oe`=1 while `nand_we_n` is low.
- R4: A data write request (`req_kind`=2'b10) drives `nand_cle`=0, `nand_ale`=0 and `nand_ce_n`=0. It drives `req_byte` on `nand_dq_out` with `nand_dq_oe`=1 while `nand_we_n` is low.
- R5: For kinds 2'b00 to 2'b10, `nand_we_n` is low for exactly `WE_LOW` clocks and `nand_re_n` stays high. After the rise, `nand_ce_n`=0, both latch-select levels and the driven byte are all held for `WE_HIGH` clocks. `ack` is then a one-clock pulse in clock `WE_LOW`+`WE_HIGH`+1 after the accepting edge.
- R6: A read request (`req_kind`=2'b11) drives `nand_re_n` low for `WE_LOW` clocks with `nand_ce_n`=0, `nand_dq_oe`=0 and `nand_we_n` high. The block returns the `nand_dq_in` value of the last low clock on `rd_data`, with `rd_valid` high only in the clock where `ack` is high.
- R7: `nand_cle` and `nand_ale` are never high together. The two strobes are never low together. `nand_ce_n` is low whenever either strobe is low.
- R8: A command with `req_wait`=1 waits for ready/busy after the strobe. It ignores `nand_rb` for `BLANK_CYC` clocks, and then acknowledges once the two-flop synchronised `nand_rb` is high, with `timeout_err`=0. If `nand_rb` stays high, `ack` comes in clock `WE_LOW`+`WE_HIGH`+`BLANK_CYC`+2.
- R9: If `nand_rb` is still low after `TIMEOUT_CYC` clocks of waiting, `ack` pulses in clock `WE_LOW`+`WE_HIGH`+`BLANK_CYC`+`TIMEOUT_CYC`+1 with `timeout_err`=1. `timeout_err` is never high without `ack`.
- R10: `req_wait` has no effect on kinds other than command. Such cycles are acknowledged after `WE_LOW`+`WE_HIGH`+1 clocks with `timeout_err`=0, even while `nand_rb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request, held until ack |
| req_kind | input | 2 | Cycle kind: 00 command, 01 address, 10 write, 11 read |
| req_byte | input | DW | Byte to place on the bus |
| req_wait | input | 1 | Wait for ready after this command |
| ack | output | 1 | One-clock completion pulse |
| rd_valid | output | 1 | Read byte valid (with ack) |
| rd_data | output | DW | Byte returned by a read |
| timeout_err | output | 1 | Busy wait expired (with ack) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch select |
| nand_ale | output | 1 | Address latch select |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | DW | Bus value driven to the device |
| nand_dq_oe | output | 1 | Bus drive enable |
| nand_dq_in | input | DW | Bus value from the device |
| nand_rb | input | 1 | Ready (1) / busy (0) |

## Verification
The assertions check the protocol on every clock:
- the two latch selects are never high together, and the two strobes are never low together;
- chip enable is low whenever a strobe is low;
- the write strobe is low for exactly the programmed width;
- the latch selects and the byte stay stable through the write strobe and its rise;
- `ack` is a single-clock pulse, and read-valid and timeout flags appear only with it.

Only the bench scenarios show the rest:
- that each kind selects the right latch levels and places the requested byte on the bus;
- that a read returns the device byte sampled at the end of the read strobe;
- the exact acknowledge latency with and without the busy wait;
- that a device stuck busy ends in a timeout;
- that the wait flag is ignored on kinds other than command;
- that a reset in the middle of a cycle returns the bus to idle.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [1:0] {
        KIND_CMD   = 2'b00,
        KIND_ADDR  = 2'b01,
        KIND_WRITE = 2'b10,
        KIND_READ  = 2'b11
    } cyc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STROBE_LO,
        ST_STROBE_HI,
        ST_BLANK,
        ST_BUSY,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/nand_phase_cnt.sv
// Down counter that times one strobe phase; last is high on the final clock.
module nand_phase_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/nand_rb_watch.sv
// Synchronises ready/busy and times the busy wait.
module nand_rb_watch #(
    parameter int TIMEOUT_CYC = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nand_rb,
    input  logic run,
    output logic ready,
    output logic expired
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    logic          rb_s1, rb_s2;
    logic [TW-1:0] wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_s1 <= 1'b1;
            rb_s2 <= 1'b1;
        end else begin
            rb_s1 <= nand_rb;
            rb_s2 <= rb_s1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (!run) begin
            wait_cnt <= '0;
        end else begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    assign ready   = rb_s2;
    assign expired = run && (wait_cnt == TW'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
    import nand_seq_pkg::*;
#(
    parameter int DW          = 8,
    parameter int WE_LOW      = 2,
    parameter int WE_HIGH     = 2,
    parameter int BLANK_CYC   = 4,
    parameter int TIMEOUT_CYC = 300000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [DW-1:0] req_byte,
    input  logic          req_wait,
    output logic          ack,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          timeout_err,
    output logic          nand_ce_n,
    output logic          nand_cle,
    output logic          nand_ale,
    output logic          nand_we_n,
    output logic          nand_re_n,
    output logic [DW-1:0] nand_dq_out,
    output logic          nand_dq_oe,
    input  logic [DW-1:0] nand_dq_in,
    input  logic          nand_rb
);
    localparam int MAX_STROBE = (WE_LOW > WE_HIGH) ? WE_LOW : WE_HIGH;
    localparam int MAX_PHASE  = (MAX_STROBE > BLANK_CYC) ? MAX_STROBE : BLANK_CYC;
    localparam int PW         = $clog2(MAX_PHASE + 1);

    seq_state_e    state_q, state_d;
    cyc_kind_e     kind_q;
    logic [DW-1:0] byte_q;
    logic          wait_q;
    logic [DW-1:0] rd_q;
    logic          err_q;

    logic          ph_load;
    logic [PW-1:0] ph_val;
    logic          ph_last;
    logic          rb_ready;
    logic          rb_expired;
    logic          accept;

    assign accept = (state_q == ST_IDLE) && req_valid;

    nand_phase_cnt #(.W(PW)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .last     (ph_last)
    );

    nand_rb_watch #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rbw (
        .clk     (clk),
        .rst_n   (rst_n),
        .nand_rb (nand_rb),
        .run     (state_q == ST_BUSY),
        .ready   (rb_ready),
        .expired (rb_expired)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_STROBE_LO;
            ST_STROBE_LO: if (ph_last)   state_d = ST_STROBE_HI;
            ST_STROBE_HI: if (ph_last)   state_d = (wait_q && kind_q == KIND_CMD) ? ST_BLANK : ST_DONE;
            ST_BLANK:     if (ph_last)   state_d = ST_BUSY;
            ST_BUSY:      if (rb_ready || rb_expired) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Phase timer load on entry to a timed state
    always_comb begin
        ph_load = (state_d != state_q);
        unique case (state_d)
            ST_STROBE_LO: ph_val = PW'(WE_LOW - 1);
            ST_STROBE_HI: ph_val = PW'(WE_HIGH - 1);
            ST_BLANK:     ph_val = PW'(BLANK_CYC - 1);
            default:      ph_val = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture, read sampling and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= KIND_CMD;
            byte_q <= '0;
            wait_q <= 1'b0;
            rd_q   <= '0;
            err_q  <= 1'b0;
        end else begin
            if (accept) begin
                kind_q <= cyc_kind_e'(req_kind);
                byte_q <= req_byte;
                wait_q <= req_wait;
                err_q  <= 1'b0;
            end
            if (state_q == ST_STROBE_LO && ph_last && kind_q == KIND_READ)
                rd_q <= nand_dq_in;
            if (state_q == ST_BUSY && !rb_ready && rb_expired)
                err_q <= 1'b1;
        end
    end

    // Outputs decoded from the state register
    always_comb begin
        nand_ce_n   = 1'b1;
        nand_cle    = 1'b0;
        nand_ale    = 1'b0;
        nand_we_n   = 1'b1;
        nand_re_n   = 1'b1;
        nand_dq_out = '0;
        nand_dq_oe  = 1'b0;
        ack         = 1'b0;
        rd_valid    = 1'b0;
        timeout_err = 1'b0;
        unique case (state_q)
            ST_STROBE_LO, ST_STROBE_HI: begin
                nand_ce_n = 1'b0;
                nand_cle  = (kind_q == KIND_CMD);
                nand_ale  = (kind_q == KIND_ADDR);
                if (kind_q == KIND_READ) begin
                    nand_re_n = (state_q != ST_STROBE_LO);
                end else begin
                    nand_we_n   = (state_q != ST_STROBE_LO);
                    nand_dq_out = byte_q;
                    nand_dq_oe  = 1'b1;
                end
            end
            ST_BLANK, ST_BUSY: nand_ce_n = 1'b0;
            ST_DONE: begin
                ack         = 1'b1;
                rd_valid    = (kind_q == KIND_READ);
                timeout_err = err_q;
            end
            default: ;
        endcase
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/nand_bus_seq_chk.sv
module nand_bus_seq_chk #(
    parameter int DW     = 8,
    parameter int WE_LOW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack,
    input logic          rd_valid,
    input logic          timeout_err,
    input logic          nand_ce_n,
    input logic          nand_cle,
    input logic          nand_ale,
    input logic          nand_we_n,
    input logic          nand_re_n,
    input logic [DW-1:0] nand_dq_out
);
    logic [15:0] lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          lo_cnt <= '0;
        else if (!nand_we_n) lo_cnt <= lo_cnt + 1'b1;
        else                 lo_cnt <= '0;
    end

    // R7
    latch_sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    // R7
    ce_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    // R5
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> (lo_cnt == 16'(WE_LOW)));

    // R5
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |=> ($stable(nand_dq_out) && $stable(nand_cle) && $stable(nand_ale) && !nand_ce_n));

    // R5
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R6
    rd_valid_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ack);

    // R9
    timeout_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> ack);
endmodule

bind nand_bus_seq nand_bus_seq_chk #(.DW(DW), .WE_LOW(WE_LOW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack         (ack),
    .rd_valid    (rd_valid),
    .timeout_err (timeout_err),
    .nand_ce_n   (nand_ce_n),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_dq_out (nand_dq_out)
);

// File: tb/sim_nand_bus_seq.sv
`timescale 1ns/1ps
module sim_nand_bus_seq;
    localparam int WL = 3;
    localparam int WH = 2;
    localparam int BL = 4;
    localparam int TO = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'b00;
    logic [7:0] req_byte = 8'h00;
    logic       req_wait = 1'b0;
    logic       ack, rd_valid, timeout_err;
    logic [7:0] rd_data;
    logic       nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0] nand_dq_out, nand_dq_in;
    logic       nand_rb = 1'b1;
    logic [7:0] rd_pat = 8'h00;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign nand_dq_in = nand_re_n ? 8'h00 : rd_pat;

    nand_bus_seq #(.DW(8), .WE_LOW(WL), .WE_HIGH(WH), .BLANK_CYC(BL), .TIMEOUT_CYC(TO)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_byte(req_byte), .req_wait(req_wait), .ack(ack), .rd_valid(rd_valid),
        .rd_data(rd_data), .timeout_err(timeout_err), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
    );

    // {kind[2], byte[8], wait, rb_mode[2], latency[16] (0 = range), err}
    // rb_mode: 0 stays high, 1 low then high at clock 60, 2 stays low
    localparam int NV = 10;
    localparam logic [29:0] VEC [NV] = '{
        {2'b00, 8'h80, 1'b0, 2'd0, 16'd6,   1'b0},
        {2'b01, 8'h12, 1'b0, 2'd0, 16'd6,   1'b0},
        {2'b01, 8'h34, 1'b1, 2'd2, 16'd6,   1'b0},
        {2'b10, 8'hA5, 1'b0, 2'd0, 16'd6,   1'b0},
        {2'b10, 8'h5A, 1'b1, 2'd0, 16'd6,   1'b0},
        {2'b00, 8'h10, 1'b1, 2'd1, 16'd0,   1'b0},
        {2'b00, 8'h00, 1'b1, 2'd0, 16'd11,  1'b0},
        {2'b11, 8'hC3, 1'b0, 2'd0, 16'd6,   1'b0},
        {2'b11, 8'h3C, 1'b1, 2'd2, 16'd6,   1'b0},
        {2'b00, 8'hD0, 1'b1, 2'd2, 16'd310, 1'b1}
    };

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string what);
        chk("R1", {what, " ce_n"}, int'(nand_ce_n), 1);
        chk("R1", {what, " cle"}, int'(nand_cle), 0);
        chk("R1", {what, " ale"}, int'(nand_ale), 0);
        chk("R1", {what, " we_n"}, int'(nand_we_n), 1);
        chk("R1", {what, " re_n"}, int'(nand_re_n), 1);
        chk("R1", {what, " dq_oe"}, int'(nand_dq_oe), 0);
        chk("R1", {what, " ack"}, int'(ack), 0);
        chk("R1", {what, " rd_valid"}, int'(rd_valid), 0);
        chk("R1", {what, " timeout_err"}, int'(timeout_err), 0);
    endtask

    task automatic run_vec(input logic [29:0] v);
        logic [1:0] kind;
        logic [7:0] bval;
        logic       wt;
        logic [1:0] rbm;
        int         lat_exp;
        logic       err_exp;
        int n, lo_w, lo_r, hold;
        bit hold_open, got;
        logic s_cle, s_ale, s_ce, s_oe;
        logic [7:0] s_dq;
        logic a_err, a_rdv;
        logic [7:0] a_rdb;
        string ktag, ltag;
        {kind, bval, wt, rbm, lat_exp, err_exp} = {v[29:28], v[27:20], v[19], v[18:17], int'(v[16:1]), v[0]};
        ktag = (kind == 2'b00) ? "R2" : (kind == 2'b01) ? "R3" : (kind == 2'b10) ? "R4" : "R6";
        if (kind != 2'b00 && wt) ltag = "R10";
        else if (kind == 2'b00 && wt && rbm == 2'd2) ltag = "R9";
        else if (kind == 2'b00 && wt) ltag = "R8";
        else ltag = "R5";
        n = 0; lo_w = 0; lo_r = 0; hold = 0; hold_open = 0; got = 0;
        s_cle = 0; s_ale = 0; s_ce = 1; s_oe = 0; s_dq = 0;
        a_err = 0; a_rdv = 0; a_rdb = 0;
        @(negedge clk);
        rd_pat = bval;
        req_kind = kind; req_byte = bval; req_wait = wt; req_valid = 1'b1;
        while (!got && n < 2000) begin
            @(negedge clk);
            n++;
            if (rbm != 2'd0 && n == 1) nand_rb = 1'b0;
            if (rbm == 2'd1 && n == 60) nand_rb = 1'b1;
            if (!nand_re_n) lo_r++;
            if (!nand_we_n) begin
                lo_w++;
                s_cle = nand_cle; s_ale = nand_ale; s_ce = nand_ce_n;
                s_dq = nand_dq_out; s_oe = nand_dq_oe;
                hold_open = 1; hold = 0;
            end else if (hold_open) begin
                if (!nand_ce_n && nand_dq_oe && nand_cle == s_cle && nand_ale == s_ale && nand_dq_out == s_dq)
                    hold++;
                else
                    hold_open = 0;
            end
            if (kind == 2'b11 && !nand_re_n) begin
                s_cle = nand_cle; s_ale = nand_ale; s_ce = nand_ce_n; s_oe = nand_dq_oe;
            end
            if (ack) begin
                got = 1; a_err = timeout_err; a_rdv = rd_valid; a_rdb = rd_data;
            end
        end
        req_valid = 1'b0;
        nand_rb = 1'b1;
        if (lat_exp != 0) chk(ltag, "ack latency", n, lat_exp);
        else begin
            chk(ltag, "ack latency in window", int'(n > 55 && n < 80), 1);
        end
        chk(ltag, "timeout_err", int'(a_err), int'(err_exp));
        chk(ktag, "cle", int'(s_cle), int'(kind == 2'b00));
        chk(ktag, "ale", int'(s_ale), int'(kind == 2'b01));
        chk(ktag, "ce_n during strobe", int'(s_ce), 0);
        if (kind == 2'b11) begin
            chk("R6", "re_n low width", lo_r, WL);
            chk("R6", "we_n low clocks", lo_w, 0);
            chk("R6", "dq_oe during read", int'(s_oe), 0);
            chk("R6", "rd_valid", int'(a_rdv), 1);
            chk("R6", "rd_data", int'(a_rdb), int'(bval));
        end else begin
            chk(ktag, "dq at we rise", int'(s_dq), int'(bval));
            chk(ktag, "dq_oe", int'(s_oe), 1);
            chk("R5", "we_n low width", lo_w, WL);
            chk("R5", "re_n low clocks", lo_r, 0);
            chk("R5", "hold clocks", hold, WH);
            chk("R5", "rd_valid on write kind", int'(a_rdv), 0);
        end
        @(negedge clk);
        chk("R5", "ack single pulse", int'(ack), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("after reset");

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // Mid-cycle reset returns the bus to idle (R1)
        @(negedge clk);
        req_kind = 2'b00; req_byte = 8'h60; req_wait = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R2", "we_n low before mid reset", int'(nand_we_n), 0);
        rst_n = 1'b0;
        req_valid = 1'b0;
        #1;
        chk_idle("mid-cycle reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("after mid-cycle reset");

        // Back-to-back reads after reset still work (R6)
        run_vec({2'b11, 8'h96, 1'b0, 2'd0, 16'd6, 1'b0});

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule